// File: doc/BRIEF.md
# Configurable Vectored Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing outputs: a normal interrupt line and a fast interrupt line. Software programs each source independently through a small word-addressed register bus. Each source can be level or edge sensitive, and can be active high (rising) or active low (falling). A per-source enable mask and a per-source fast-path select complete the configuration.

Every source input is first synchronised through a chain of flops. Its polarity is then applied. A level source reports its corrected input directly. An edge source records a matching transition in a sticky bit, which software acknowledges by writing a one to that bit. Enabled pending sources marked for the fast path drive the fast output. All other enabled pending sources are ORed onto the normal output. A handler reads the masked status word and services the lowest set bit first.

Top module: `vec_intc`

## Requirements
- R1: After reset the enable, polarity, trigger-type and fast-select registers all read zero. Both interrupt outputs are low.
- R2: Registers sit at word addresses 0 (enable), 1 (raw pending), 2 (masked status), 3 (polarity), 4 (trigger type) and 5 (fast select). A read with busSel=1 and busWr=0 returns the addressed word combinationally. Addresses 6 and 7 read zero. Writes to the status word change nothing.
- R3: A source whose trigger-type bit is 0 is level sensitive. Its raw bit equals the synchronised input when its polarity bit is 1, and the inverted input when its polarity bit is 0. Writes to its raw bit have no effect.
- R4: A source whose trigger-type bit is 1 sets its raw bit on a rising input edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The bit stays set after the input returns. An opposite-direction edge does not set it.
- R5: Writing 1 to a bit of the raw word clears that source's latched edge event. Writing 0 leaves it as it was.
- R6: When a qualifying edge is detected in the same cycle as a write-one clear for that source, the raw bit remains set.
- R7: The status word equals the raw word ANDed with the enable mask. A source whose enable bit is 0 affects neither output.
- R8: irqOut is the OR of enabled pending sources whose fast-select bit is 0. fiqOut is the OR of enabled pending sources whose fast-select bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Asynchronous interrupt source lines |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no read is requested |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The checker watches on every cycle that each output is backed by an enabled pending source on the matching path. It also watches that enable writes land one cycle later, that unused addresses read zero, and that nothing is asserted straight after reset. Scenario-dependent behaviour is left to the bench's directed sequences. This covers the direction of edge detection, the stickiness of latched events, write-one-clear against write-zero, an edge colliding with its own acknowledge, and the immunity of level sources to raw-word writes.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    ADDR_ENABLE = 3'd0,
    ADDR_RAW    = 3'd1,
    ADDR_STATUS = 3'd2,
    ADDR_POL    = 3'd3,
    ADDR_TRIG   = 3'd4,
    ADDR_FAST   = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic wrEnable;
    logic wrAck;
    logic wrPol;
    logic wrTrig;
    logic wrFast;
  } regStrobe_t;

endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               busSel,
  input  logic               busWr,
  input  logic [REG_AW-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] maskReg,
  input  logic [NUM_SRC-1:0] rawBits,
  input  logic [NUM_SRC-1:0] polReg,
  input  logic [NUM_SRC-1:0] typeReg,
  input  logic [NUM_SRC-1:0] fiqReg,
  output regStrobe_t         strobe,
  output logic [NUM_SRC-1:0] rdata
);

  logic doWrite;
  logic doRead;

  assign doWrite = busSel & busWr;
  assign doRead  = busSel & ~busWr;

  always_comb begin
    strobe = '0;
    if (doWrite) begin
      case (busAddr)
        ADDR_ENABLE: strobe.wrEnable = 1'b1;
        ADDR_RAW:    strobe.wrAck    = 1'b1;
        ADDR_POL:    strobe.wrPol    = 1'b1;
        ADDR_TRIG:   strobe.wrTrig   = 1'b1;
        ADDR_FAST:   strobe.wrFast   = 1'b1;
        default:     strobe          = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (doRead) begin
      case (busAddr)
        ADDR_ENABLE: rdata = maskReg;
        ADDR_RAW:    rdata = rawBits;
        ADDR_STATUS: rdata = rawBits & maskReg;
        ADDR_POL:    rdata = polReg;
        ADDR_TRIG:   rdata = typeReg;
        ADDR_FAST:   rdata = fiqReg;
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [NUM_SRC-1:0] polReg,
  output logic [NUM_SRC-1:0] typeReg,
  output logic [NUM_SRC-1:0] fiqReg,
  output logic [NUM_SRC-1:0] rawBits,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] syncd;
  logic [NUM_SRC-1:0] prevSync;
  logic [NUM_SRC-1:0] edgeHit;
  logic [NUM_SRC-1:0] levelAct;
  logic [NUM_SRC-1:0] edgeLatch;
  logic [NUM_SRC-1:0] ackMask;
  logic [NUM_SRC-1:0] pending;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0;
      polReg  <= '0;
      typeReg <= '0;
      fiqReg  <= '0;
    end else begin
      if (strobe.wrEnable) maskReg <= wdata;
      if (strobe.wrPol)    polReg  <= wdata;
      if (strobe.wrTrig)   typeReg <= wdata;
      if (strobe.wrFast)   fiqReg  <= wdata;
    end
  end

  // input synchroniser and previous-value register for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ    <= '0;
      prevSync <= '0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], srcIn};
      prevSync <= syncd;
    end
  end

  assign syncd = syncQ[LAST_STAGE];

  // per-source trigger qualification
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic riseSeen;
    logic fallSeen;
    assign riseSeen    = syncd[i] & ~prevSync[i];
    assign fallSeen    = ~syncd[i] & prevSync[i];
    assign edgeHit[i]  = polReg[i] ? riseSeen : fallSeen;
    assign levelAct[i] = ~(syncd[i] ^ polReg[i]);
    assign rawBits[i]  = typeReg[i] ? edgeLatch[i] : levelAct[i];
  end

  assign ackMask = strobe.wrAck ? wdata : '0;

  // sticky edge events: a new edge overrides a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeLatch <= '0;
    end else begin
      edgeLatch <= typeReg & (edgeHit | (edgeLatch & ~ackMask));
    end
  end

  assign pending = rawBits & maskReg;
  assign irqOut  = |(pending & ~fiqReg);
  assign fiqOut  = |(pending & fiqReg);

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [REG_AW-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] polReg;
  logic [NUM_SRC-1:0] typeReg;
  logic [NUM_SRC-1:0] fiqReg;
  logic [NUM_SRC-1:0] rawBits;

  vec_intc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .maskReg (maskReg),
    .rawBits (rawBits),
    .polReg  (polReg),
    .typeReg (typeReg),
    .fiqReg  (fiqReg),
    .strobe  (strobe),
    .rdata   (busRdata)
  );

  vec_intc_dp #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .srcIn   (srcIn),
    .strobe  (strobe),
    .wdata   (busWdata),
    .maskReg (maskReg),
    .polReg  (polReg),
    .typeReg (typeReg),
    .fiqReg  (fiqReg),
    .rawBits (rawBits),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busSel,
  input logic               busWr,
  input logic [2:0]         busAddr,
  input logic [NUM_SRC-1:0] busWdata,
  input logic [NUM_SRC-1:0] busRdata,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] maskReg,
  input logic [NUM_SRC-1:0] polReg,
  input logic [NUM_SRC-1:0] typeReg,
  input logic [NUM_SRC-1:0] fiqReg,
  input logic [NUM_SRC-1:0] rawBits
);

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (maskReg == '0 && polReg == '0 && typeReg == '0 &&
                       fiqReg == '0 && !irqOut && !fiqOut));

  // R2
  enable_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && busWr && busAddr == 3'd0) |=> (maskReg == $past(busWdata)));

  // R2
  unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWr && busAddr > 3'd5) |-> (busRdata == '0));

  // R7
  irq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (|(rawBits & maskReg & ~fiqReg)));

  // R8
  fiq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiqOut |-> (|(rawBits & maskReg & fiqReg)));

endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/vec_intc_test.sv
`timescale 1ns/1ps
module vec_intc_test;

  localparam int N = 32;
  localparam int NV = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] srcIn = '0;
  logic         busSel = 1'b0;
  logic         busWr = 1'b0;
  logic [2:0]   busAddr = '0;
  logic [N-1:0] busWdata = '0;
  logic [N-1:0] busRdata;
  logic         irqOut;
  logic         fiqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_intc uut (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // vectors: src, enable, polarity, fast, raw, status, irq, fiq (all level)
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_00F0, 32'h0, 32'h8000_0001,
                                         32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0003};
  localparam logic [31:0] V_EN  [NV] = '{32'h0000_00FF, 32'hFFFF_FFFF, 32'h8000_0000,
                                         32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0003};
  localparam logic [31:0] V_POL [NV] = '{32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                         32'h0, 32'h0, 32'h0000_0003};
  localparam logic [31:0] V_FST [NV] = '{32'h0, 32'h0, 32'h8000_0000,
                                         32'h0, 32'h0000_0001, 32'h0000_0001};
  localparam logic [31:0] V_RAW [NV] = '{32'hFFFF_FFF0, 32'h0, 32'h8000_0001,
                                         32'hFFFF_FFFE, 32'h0, 32'hFFFF_FFFF};
  localparam logic [31:0] V_STA [NV] = '{32'h0000_00F0, 32'h0, 32'h8000_0000,
                                         32'hFFFF_FFFE, 32'h0, 32'h0000_0003};
  localparam logic        V_IRQ [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        V_FIQ [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at a falling edge
  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(3'd0, rd); compare("R1 enable", rd, 32'h0);
    regRead(3'd3, rd); compare("R1 polarity", rd, 32'h0);
    regRead(3'd4, rd); compare("R1 type", rd, 32'h0);
    regRead(3'd5, rd); compare("R1 fast", rd, 32'h0);
    compare("R1 outputs", {30'h0, irqOut, fiqOut}, 32'h0);

    // R3 R7 R8: level vectors
    regWrite(3'd4, 32'h0);
    for (int v = 0; v < NV; v++) begin
      srcIn = V_SRC[v];
      regWrite(3'd0, V_EN[v]);
      regWrite(3'd3, V_POL[v]);
      regWrite(3'd5, V_FST[v]);
      settle();
      regRead(3'd1, rd); compare("R3 raw", rd, V_RAW[v]);
      regRead(3'd2, rd); compare("R7 status", rd, V_STA[v]);
      compare("R8 irq", {31'h0, irqOut}, {31'h0, V_IRQ[v]});
      compare("R8 fiq", {31'h0, fiqOut}, {31'h0, V_FIQ[v]});
    end

    // R4 R5: edge sources, bit0 rising, bit1 falling
    srcIn = '0;
    settle();
    regWrite(3'd3, 32'h1);
    regWrite(3'd4, 32'h3);
    regWrite(3'd5, 32'h0);
    regWrite(3'd0, 32'h3);
    regWrite(3'd1, 32'h3);
    settle();
    regRead(3'd1, rd); compare("R4 idle", rd & 32'h3, 32'h0);
    srcIn[0] = 1'b1; settle();
    regRead(3'd1, rd); compare("R4 rise latched", rd & 32'h3, 32'h1);
    compare("R8 irq edge", {31'h0, irqOut}, 32'h1);
    srcIn[0] = 1'b0; settle();
    regRead(3'd1, rd); compare("R4 sticky", rd & 32'h3, 32'h1);
    regWrite(3'd1, 32'h0);
    regRead(3'd1, rd); compare("R5 write zero", rd & 32'h3, 32'h1);
    regWrite(3'd1, 32'h1);
    regRead(3'd1, rd); compare("R5 write one", rd & 32'h3, 32'h0);
    compare("R5 irq dropped", {31'h0, irqOut}, 32'h0);
    srcIn[1] = 1'b1; settle();
    regRead(3'd1, rd); compare("R4 wrong direction", rd & 32'h3, 32'h0);
    srcIn[1] = 1'b0; settle();
    regRead(3'd1, rd); compare("R4 fall latched", rd & 32'h3, 32'h2);

    // R7: disabled pending source is blocked
    regWrite(3'd0, 32'h1);
    regRead(3'd2, rd); compare("R7 masked status", rd, 32'h0);
    compare("R7 outputs blocked", {30'h0, irqOut, fiqOut}, 32'h0);
    // R8: steered to fast path only
    regWrite(3'd5, 32'h2);
    regWrite(3'd0, 32'h3);
    compare("R8 fast steering", {30'h0, irqOut, fiqOut}, 32'h1);
    regWrite(3'd1, 32'h2);
    regWrite(3'd5, 32'h0);

    // R6: edge detected in the same cycle as its acknowledge
    srcIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    regWrite(3'd1, 32'h1);
    regRead(3'd1, rd); compare("R6 edge beats clear", rd & 32'h3, 32'h1);
    regWrite(3'd1, 32'h1);
    regRead(3'd1, rd); compare("R6 later clear", rd & 32'h3, 32'h0);

    // R3: level source ignores raw writes
    regWrite(3'd4, 32'h0);
    settle();
    regWrite(3'd1, 32'h1);
    regRead(3'd1, rd); compare("R3 write ignored", rd & 32'h1, 32'h1);

    // R2: unused address and read-only status word
    regRead(3'd6, rd); compare("R2 unused addr", rd, 32'h0);
    regWrite(3'd2, 32'hFFFF_FFFF);
    regRead(3'd0, rd); compare("R2 status write ignored", rd, 32'h3);
    regRead(3'd5, rd); compare("R2 fast kept", rd, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule